// File: doc/BRIEF.md
# Serial Path Overhead Byte Fetch Port

This block obtains high-order path overhead bytes from an outside agent through a small serial port and passes them to a path overhead generator. When the generator needs a byte from the port, it sends a one-cycle request that carries the byte address. The block clocks the address out serially under an address strobe. It then waits one port period with both strobes low, raises a data strobe and clocks in the 8-bit reply. Once the exchange ends, the generator receives the byte and its address on a parallel interface, qualified by a one-cycle valid pulse.

The address field `req_addr_i[3:0]` selects the overhead byte. The codes are: 0 = J1, 1 = B3, 2 = C2, 3 = G1, 4 = F2, 5 = H4, 6 = F3, 7 = K3, 8 = N1. Bits 7:4 are forwarded unchanged. Bit i of `src_sel_i` gives code i to the port; when that bit is 0, the byte comes from internal registers. The port never delivers trace (J1) or signal label (C2) bytes. A byte fetched for B3 is never delivered. It is held instead as an error mask that is XORed onto the locally computed BIP-8 while the B3 select bit is set. The port generates its own clock `pclk_o`, with a period of `CLK_DIV` system cycles that is high for the first half. Every strobe and address transition happens at a rising edge of `pclk_o`. Each serial input bit is sampled at the rising edge that closes its bit period.

Top module: `poh_fetch_port`

## Requirements
- R1: After reset, and whenever idle, `busy_o`, `pclk_o`, `ale_o`, `dle_o`, `saddr_o` and `ins_valid_o` are low, and the B3 mask is zero.
- R2: A transfer opens with 8 port periods with `ale_o` high. During them `saddr_o` carries the request address, most significant bit first, one bit per period; `saddr_o` is low whenever `ale_o` is low.
- R3: The address periods are followed by exactly one port period in which both `ale_o` and `dle_o` are low. The two strobes are never high together.
- R4: After the gap, `dle_o` is high for 8 port periods. `sdata_i` is sampled at the rising `pclk_o` edge that ends each of these periods, most significant bit first.
- R5: `busy_o` stays high for 18 port periods (18 × `CLK_DIV` system cycles): 8 address, 1 gap, 8 data and 1 completion. `pclk_o` rises once per period.
- R6: For codes 3 to 8, `ins_valid_o` pulses high for one cycle in the cycle where `busy_o` falls. It comes with the received byte on `ins_byte_o` and the full 8-bit request address on `ins_addr_o`.
- R7: For codes 0 (J1) and 2 (C2), the serial exchange runs in full but `ins_valid_o` stays low.
- R8: A request whose code has its `src_sel_i` bit clear, or whose code is 9 or above, starts no transfer.
- R9: A request that arrives while `busy_o` is high is ignored. The running transfer keeps its address, and no second transfer follows it.
- R10: For code 1 (B3), no `ins_valid_o` pulse is produced. The received byte becomes the mask, and while `src_sel_i[1]` is 1, `bip_o` = `bip_i` XOR mask.
- R11: While `src_sel_i[1]` is 0, `bip_o` equals `bip_i`. An all-zero mask also leaves `bip_i` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | One-cycle fetch request |
| req_addr_i | input | 8 | Requested byte address, code in bits 3:0 |
| src_sel_i | input | NUM_BYTES | Per-byte source select, 1 = serial port |
| busy_o | output | 1 | Transfer in progress |
| pclk_o | output | 1 | Port clock |
| ale_o | output | 1 | Address strobe |
| saddr_o | output | 1 | Serial address out, MSB first |
| dle_o | output | 1 | Data strobe |
| sdata_i | input | 1 | Serial data in, MSB first |
| ins_valid_o | output | 1 | Fetched byte valid pulse |
| ins_addr_o | output | 8 | Address of the fetched byte |
| ins_byte_o | output | 8 | Fetched byte |
| bip_i | input | 8 | Locally computed BIP-8 |
| bip_o | output | 8 | BIP-8 after optional error mask |

## Verification
A wrong period counter or step counter shows up in the first transfer. The strobe pattern, sampled at each `pclk_o` rise, moves its gap or stretches a phase, and the busy length differs from 18 × `CLK_DIV` within a single exchange. A wrong address or data shift direction appears as a bit-reversed `saddr_o` stream or `ins_byte_o` one cycle after `busy_o` falls. A faulty refusal decode or mask register appears as a stray valid pulse on J1 or C2, or as a wrong `bip_o` value, in the cycle after the B3 exchange completes.

// File: rtl/poh_fetch_pkg.sv
package poh_fetch_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;
  localparam int GAP_W  = 1;
  localparam int CODE_W = 4;
  localparam int STEPS  = ADDR_W + GAP_W + DATA_W + 1;
  localparam int STEP_W = $clog2(STEPS);

  typedef enum logic [CODE_W-1:0] {
    BC_J1 = 4'd0, BC_B3, BC_C2, BC_G1, BC_F2, BC_H4, BC_F3, BC_K3, BC_N1
  } byte_code_e;

  typedef enum logic [1:0] {PH_ADDR, PH_GAP, PH_DATA, PH_DONE} phase_e;
endpackage

// File: rtl/poh_fetch_timer.sv
// Port clock divider and step sequencer. CLK_DIV must be even and >= 2.
module poh_fetch_timer
  import poh_fetch_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  output logic   busy_o,
  output logic   tick_o,
  output logic   pclk_o,
  output phase_e phase_o
);
  localparam int DIV_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam int HALF  = CLK_DIV / 2;

  logic [DIV_W-1:0]  div_q;
  logic [STEP_W-1:0] step_q;
  logic              busy_q;

  assign tick_o = busy_q && (div_q == DIV_W'(CLK_DIV - 1));
  assign busy_o = busy_q;
  assign pclk_o = busy_q && (div_q < DIV_W'(HALF));

  always_comb begin
    if (step_q < STEP_W'(ADDR_W))                 phase_o = PH_ADDR;
    else if (step_q < STEP_W'(ADDR_W + GAP_W))    phase_o = PH_GAP;
    else if (step_q < STEP_W'(STEPS - 1))         phase_o = PH_DATA;
    else                                          phase_o = PH_DONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      div_q  <= '0;
      step_q <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      div_q  <= '0;
      step_q <= '0;
    end else if (busy_q) begin
      if (tick_o) begin
        div_q <= '0;
        if (step_q == STEP_W'(STEPS - 1)) busy_q <= 1'b0;
        else                              step_q <= step_q + 1'b1;
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/poh_fetch_shreg.sv
// Parallel-load shift register, MSB leaves first.
module poh_fetch_shreg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         shift_i,
  input  logic         ser_i,
  output logic [W-1:0] par_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      par_o <= '0;
    else if (load_i)  par_o <= load_val_i;
    else if (shift_i) par_o <= {par_o[W-2:0], ser_i};
  end
endmodule

// File: rtl/poh_fetch_b3mask.sv
module poh_fetch_b3mask #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] mask_i,
  input  logic         en_i,
  input  logic [W-1:0] bip_i,
  output logic [W-1:0] bip_o
);
  logic [W-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     mask_q <= '0;
    else if (load_i) mask_q <= mask_i;
  end

  assign bip_o = en_i ? (bip_i ^ mask_q) : bip_i;
endmodule

// File: rtl/poh_fetch_port.sv
module poh_fetch_port
  import poh_fetch_pkg::*;
#(
  parameter int CLK_DIV   = 4,
  parameter int NUM_BYTES = 9
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic [ADDR_W-1:0]    req_addr_i,
  input  logic [NUM_BYTES-1:0] src_sel_i,
  output logic                 busy_o,
  output logic                 pclk_o,
  output logic                 ale_o,
  output logic                 saddr_o,
  output logic                 dle_o,
  input  logic                 sdata_i,
  output logic                 ins_valid_o,
  output logic [ADDR_W-1:0]    ins_addr_o,
  output logic [DATA_W-1:0]    ins_byte_o,
  input  logic [DATA_W-1:0]    bip_i,
  output logic [DATA_W-1:0]    bip_o
);
  localparam int SEL_N = 2 ** CODE_W;

  logic [SEL_N-1:0]  sel_pad;
  logic [CODE_W-1:0] req_code, done_code;
  logic              start, busy, tick, done, b3_load, deliver;
  phase_e            phase;
  logic [ADDR_W-1:0] addr_sh;
  logic [DATA_W-1:0] data_sh;

  // codes beyond NUM_BYTES read as zero: never served by the port
  assign sel_pad  = SEL_N'(src_sel_i);
  assign req_code = req_addr_i[CODE_W-1:0];
  assign start    = req_i && !busy && sel_pad[req_code];

  poh_fetch_timer #(.CLK_DIV(CLK_DIV)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .busy_o  (busy),
    .tick_o  (tick),
    .pclk_o  (pclk_o),
    .phase_o (phase)
  );

  // address rotates, so after the address phase it holds the request again
  poh_fetch_shreg #(.W(ADDR_W)) u_addr_sh (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (start),
    .load_val_i (req_addr_i),
    .shift_i    (tick && phase == PH_ADDR),
    .ser_i      (addr_sh[ADDR_W-1]),
    .par_o      (addr_sh)
  );

  poh_fetch_shreg #(.W(DATA_W)) u_data_sh (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (1'b0),
    .load_val_i ('0),
    .shift_i    (tick && phase == PH_DATA),
    .ser_i      (sdata_i),
    .par_o      (data_sh)
  );

  assign busy_o  = busy;
  assign ale_o   = busy && phase == PH_ADDR;
  assign dle_o   = busy && phase == PH_DATA;
  assign saddr_o = ale_o && addr_sh[ADDR_W-1];

  assign done      = tick && phase == PH_DONE;
  assign done_code = addr_sh[CODE_W-1:0];
  assign b3_load   = done && done_code == BC_B3;
  assign deliver   = done && done_code != BC_B3 && done_code != BC_J1 && done_code != BC_C2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ins_valid_o <= 1'b0;
      ins_addr_o  <= '0;
      ins_byte_o  <= '0;
    end else begin
      ins_valid_o <= deliver;
      if (deliver) begin
        ins_addr_o <= addr_sh;
        ins_byte_o <= data_sh;
      end
    end
  end

  poh_fetch_b3mask #(.W(DATA_W)) u_b3 (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (b3_load),
    .mask_i (data_sh),
    .en_i   (src_sel_i[BC_B3]),
    .bip_i  (bip_i),
    .bip_o  (bip_o)
  );
endmodule

// File: rtl/poh_fetch_port_chk.sv
module poh_fetch_port_chk
  import poh_fetch_pkg::*;
#(
  parameter int NUM_BYTES = 9
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [NUM_BYTES-1:0] src_sel_i,
  input logic                 busy_o,
  input logic                 pclk_o,
  input logic                 ale_o,
  input logic                 saddr_o,
  input logic                 dle_o,
  input logic                 ins_valid_o,
  input logic [ADDR_W-1:0]    ins_addr_o,
  input logic [DATA_W-1:0]    bip_i,
  input logic [DATA_W-1:0]    bip_o
);
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !ale_o && !dle_o && !pclk_o);  // R1
  AST_SADDR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ale_o |-> !saddr_o);  // R2
  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ale_o && dle_o));  // R3
  AST_GAP_AFTER_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ale_o) |-> busy_o && !dle_o);  // R3
  AST_DATA_AFTER_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dle_o) |-> !$past(ale_o));  // R4
  AST_VALID_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_valid_o |-> $fell(busy_o));  // R5
  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_valid_o |=> !ins_valid_o);  // R6
  AST_NO_REFUSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_valid_o |-> ins_addr_o[CODE_W-1:0] > BC_C2);  // R7
  AST_BIP_BYPASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !src_sel_i[BC_B3] |-> bip_o == bip_i);  // R11
endmodule

bind poh_fetch_port poh_fetch_port_chk #(.NUM_BYTES(NUM_BYTES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .src_sel_i   (src_sel_i),
  .busy_o      (busy_o),
  .pclk_o      (pclk_o),
  .ale_o       (ale_o),
  .saddr_o     (saddr_o),
  .dle_o       (dle_o),
  .ins_valid_o (ins_valid_o),
  .ins_addr_o  (ins_addr_o),
  .bip_i       (bip_i),
  .bip_o       (bip_o)
);

// File: tb/sim_poh_fetch_port.sv
module sim_poh_fetch_port;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;
  localparam int NB         = 9;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0;
  logic [7:0]    req_addr = '0;
  logic [NB-1:0] sel = '1;
  logic          busy, pclk, ale, saddr, dle, ins_valid;
  logic          sdata = 1'b0;
  logic [7:0]    ins_addr, ins_byte;
  logic [7:0]    bip = 8'hA5;
  logic [7:0]    bip_out;
  int            n_checks = 0;
  int            n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  poh_fetch_port #(.CLK_DIV(DIV), .NUM_BYTES(NB)) u0 (
    .clk_i (clk), .rst_ni (rst_n), .req_i (req), .req_addr_i (req_addr),
    .src_sel_i (sel), .busy_o (busy), .pclk_o (pclk), .ale_o (ale),
    .saddr_o (saddr), .dle_o (dle), .sdata_i (sdata), .ins_valid_o (ins_valid),
    .ins_addr_o (ins_addr), .ins_byte_o (ins_byte), .bip_i (bip), .bip_o (bip_out)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // One full exchange; agent answers with d; optional request while busy.
  task automatic xfer(input logic [7:0] a, input logic [7:0] d, input bit deliver,
                      input bit poke, input logic [7:0] poke_a);
    int busy_cyc = 0, rises = 0, dk = 0;
    bit addr_ok = 1, gap_ok = 1, data_ok = 1;
    logic prev = 1'b0;
    logic [7:0] got_a = '0;
    bit v;
    logic [7:0] va, vb;
    req = 1'b1; req_addr = a;
    @(negedge clk);
    req = 1'b0;
    while (busy && busy_cyc < 2000) begin
      busy_cyc++;
      if (pclk && !prev) begin
        if (rises < 8) begin
          if (ale !== 1'b1 || dle !== 1'b0) addr_ok = 0;
        end else if (rises == 8) begin
          if (ale !== 1'b0 || dle !== 1'b0) gap_ok = 0;
        end else if (rises <= 16) begin
          if (ale !== 1'b0 || dle !== 1'b1) data_ok = 0;
        end else if (ale !== 1'b0 || dle !== 1'b0) gap_ok = 0;
        if (ale) got_a = {got_a[6:0], saddr};
        if (dle && dk < 8) begin sdata = d[7-dk]; dk++; end
        rises++;
      end
      prev = pclk;
      if (poke && busy_cyc == 20) begin req = 1'b1; req_addr = poke_a; end
      else req = 1'b0;
      @(negedge clk);
    end
    v = ins_valid; va = ins_addr; vb = ins_byte;
    chk(busy_cyc == 18 * DIV, "R5 busy length", busy_cyc, 18 * DIV);
    chk(rises == 18, "R5 port clock rises", rises, 18);
    chk(addr_ok, "R2 address strobe periods", 0, 1);
    chk(got_a == a, "R2 serial address", got_a, a);
    chk(gap_ok, "R3 idle gap", 0, 1);
    chk(data_ok, "R4 data strobe periods", 0, 1);
    if (deliver) begin
      chk(v == 1'b1, "R6 valid at busy fall", v, 1);
      chk(va == a, "R6 delivered address", va, a);
      chk(vb == d, "R4 delivered byte", vb, d);
    end else begin
      chk(v == 1'b0, "R7 no delivery", v, 0);
    end
    @(negedge clk);
    chk(ins_valid == 1'b0, "R6 single-cycle valid", ins_valid, 0);
    chk(busy == 1'b0, "R9 no follow-on transfer", busy, 0);
  endtask

  task automatic no_start(input logic [7:0] a);
    bit moved = 0;
    req = 1'b1; req_addr = a;
    @(negedge clk);
    req = 1'b0;
    for (int i = 0; i < 3 * DIV; i++) begin
      if (busy || pclk || ale || ins_valid) moved = 1;
      @(negedge clk);
    end
    chk(!moved, "R8 request not served", moved, 0);
  endtask

  task automatic test_reset();
    chk(busy == 0 && pclk == 0 && ale == 0 && dle == 0 && saddr == 0,
        "R1 idle outputs", {busy, pclk, ale, dle, saddr}, 0);
    chk(ins_valid == 0, "R1 valid low", ins_valid, 0);
    chk(bip_out == bip, "R11 zero mask after reset", bip_out, bip);
  endtask

  task automatic test_b3();
    xfer(8'h01, 8'h81, 1'b0, 1'b0, 8'h00);
    bip = 8'h3C;
    @(negedge clk);
    chk(bip_out == 8'hBD, "R10 mask applied", bip_out, 8'hBD);
    sel[1] = 1'b0;
    @(negedge clk);
    chk(bip_out == 8'h3C, "R11 bypass when deselected", bip_out, 8'h3C);
    sel[1] = 1'b1;
    xfer(8'h01, 8'h00, 1'b0, 1'b0, 8'h00);
    bip = 8'h5A;
    @(negedge clk);
    chk(bip_out == 8'h5A, "R11 zero mask passes", bip_out, 8'h5A);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    xfer(8'h53, 8'hC6, 1'b1, 1'b0, 8'h00);   // R6 G1
    xfer(8'hA8, 8'h3B, 1'b1, 1'b0, 8'h00);   // R6 N1
    xfer(8'h70, 8'hFF, 1'b0, 1'b0, 8'h00);   // R7 J1
    xfer(8'h12, 8'h99, 1'b0, 1'b0, 8'h00);   // R7 C2
    xfer(8'h27, 8'h4E, 1'b1, 1'b1, 8'h04);   // R9 request while busy
    no_start(8'h0B);                         // R8 code out of range
    sel[4] = 1'b0;
    no_start(8'h04);                         // R8 deselected
    sel[4] = 1'b1;
    test_b3();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule